// File: doc/BRIEF.md
# Grouped Maskable Interrupt Aggregator

This block gathers interrupt events from many sources and presents them to a host as a two-level register structure with a single active-low request line. Each source owns one status bit inside one of several equally wide groups. The lower groups are fed from asynchronous pins: every pin is brought into the clock domain through a synchronizer and watched for edges whose polarity is chosen per pin. The upper groups are fed directly by single-cycle synchronous event pulses, such as those from a keyboard matrix scanner.

A status bit latches whether or not it is enabled. Each group has an enable (mask) register in which 1 means enabled. Software reads a read-only summary register to learn which groups hold an enabled, pending event. It then reads that group's status and mask, ANDs them, and clears the events it has handled by writing ones to the status register. The request line is low while any enabled status bit is set. Register access is a plain synchronous write strobe with a combinational read path.

Top module: `irq_aggregator`

## Requirements
- R1: After reset every status bit and every mask bit is 0, every rising-edge enable is 1, every falling-edge enable is 0, and `irq_n` is 1.
- R2: On a pin group, a 0-to-1 change on a pin whose rising-edge enable is 1 sets that pin's status bit. The bit reads as 1 on the third rising clock edge after the pin changes (two synchronizer stages plus one edge stage).
- R3: A 1-to-0 change on a pin sets its status bit only when its falling-edge enable is 1. With both enables at 1 either change sets it. With both at 0 neither change does.
- R4: On an event group, a one-cycle pulse on a `scan_evt` bit sets the matching status bit at the next rising clock edge.
- R5: Writing a status register clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R6: When an event for a bit occurs in the same cycle as a write of 1 to clear that bit, the bit stays set.
- R7: Status bits latch whether or not their mask bit is 1. A set but masked bit leaves `irq_n` at 1.
- R8: `irq_n` is 0 exactly when some group has a status bit and its mask bit both at 1. Writing a mask bit of 1 over an already-set status bit drives `irq_n` low right after that write's clock edge.
- R9: The summary register has bit g set when group g has any status bit with its mask bit at 1. The summary register ignores writes.
- R10: The address layout is as follows. `addr[1:0]` selects the register kind: 0 is status, 1 is mask, 2 is rising-edge enable and 3 is falling-edge enable. `addr[ADDR_W-1:2]` selects the group. Group index NUM_GROUPS with kind 0 is the summary register. Every other address reads 0. The edge enables of event groups read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | EDGE_GROUPS*GROUP_W | Asynchronous pins, group g in bits g*GROUP_W upward |
| scan_evt | input | (NUM_GROUPS-EDGE_GROUPS)*GROUP_W | Synchronous event pulses for the event groups |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register address (group, kind) |
| wdata | input | GROUP_W | Write data |
| rdata | output | GROUP_W | Combinational read data for `addr` |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The checker assumes that pin inputs change slowly compared with the clock, so that each change crosses the synchronizer as one clean edge. It also assumes that `scan_evt` is synchronous to `clk`. The bench holds every pin level for several cycles and drives pins and pulses only just after the falling clock edge. The per-bit properties assume that a set can come only from a detected edge or an event pulse. The bench therefore never writes a status register while it expects a bit to stay unchanged, apart from the deliberate clear-versus-event collision.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

   typedef enum logic [1:0] {
      KIND_STATUS = 2'd0,
      KIND_MASK   = 2'd1,
      KIND_RISE   = 2'd2,
      KIND_FALL   = 2'd3
   } reg_kind_e;

   localparam int KIND_W = 2;

   function automatic int grp_index_width(input int groups);
      return (groups < 1) ? 1 : $clog2(groups + 1);
   endfunction

endpackage

// File: rtl/irq_sync_edge.sv
module irq_sync_edge #(
   parameter int WIDTH       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] pin,
   input  logic             we_rise,
   input  logic             we_fall,
   input  logic [WIDTH-1:0] wdata,
   output logic [WIDTH-1:0] rise_en,
   output logic [WIDTH-1:0] fall_en,
   output logic [WIDTH-1:0] evt
);

   if (SYNC_STAGES < 2) begin : g_bad_stages
      $error("irq_sync_edge: SYNC_STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("irq_sync_edge: WIDTH must be positive");
   end

   logic [SYNC_STAGES-1:0][WIDTH-1:0] sync_q;
   logic [WIDTH-1:0]                  last_q;
   logic [WIDTH-1:0]                  level;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q[0] <= '0;
      end else begin
         sync_q[0] <= pin;
      end
   end

   for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            sync_q[s] <= '0;
         end else begin
            sync_q[s] <= sync_q[s-1];
         end
      end
   end

   assign level = sync_q[SYNC_STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         last_q  <= '0;
         rise_en <= '1;
         fall_en <= '0;
      end else begin
         last_q <= level;
         if (we_rise) rise_en <= wdata;
         if (we_fall) fall_en <= wdata;
      end
   end

   assign evt = (level & ~last_q & rise_en) | (~level & last_q & fall_en);

endmodule

// File: rtl/irq_status_group.sv
module irq_status_group #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] evt,
   input  logic             clr_we,
   input  logic             mask_we,
   input  logic [WIDTH-1:0] wdata,
   output logic [WIDTH-1:0] status,
   output logic [WIDTH-1:0] mask,
   output logic             active
);

   logic [WIDTH-1:0] clr_bits;

   assign clr_bits = clr_we ? wdata : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status <= '0;
         mask   <= '0;
      end else begin
         status <= (status & ~clr_bits) | evt;
         if (mask_we) mask <= wdata;
      end
   end

   assign active = |(status & mask);

endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
   import irq_agg_pkg::*;
#(
   parameter int  NUM_GROUPS  = 3,
   parameter int  EDGE_GROUPS = 2,
   parameter int  GROUP_W     = 8,
   parameter int  SYNC_STAGES = 2,
   localparam int GIDX_W      = grp_index_width(NUM_GROUPS),
   localparam int ADDR_W      = GIDX_W + KIND_W,
   localparam int PIN_W       = EDGE_GROUPS * GROUP_W,
   localparam int EVT_W       = (NUM_GROUPS - EDGE_GROUPS) * GROUP_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [PIN_W-1:0]  pin_in,
   input  logic [EVT_W-1:0]  scan_evt,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [GROUP_W-1:0] wdata,
   output logic [GROUP_W-1:0] rdata,
   output logic              irq_n
);

   localparam int TOTAL_W = NUM_GROUPS * GROUP_W;

   if (EDGE_GROUPS < 1 || EDGE_GROUPS >= NUM_GROUPS) begin : g_bad_split
      $error("irq_aggregator: need 1 <= EDGE_GROUPS < NUM_GROUPS");
   end
   if (NUM_GROUPS > GROUP_W) begin : g_bad_summary
      $error("irq_aggregator: summary must fit in GROUP_W bits");
   end

   reg_kind_e         kind;
   logic [GIDX_W-1:0] grp_sel;

   assign kind    = reg_kind_e'(addr[KIND_W-1:0]);
   assign grp_sel = addr[ADDR_W-1:KIND_W];

   logic [GROUP_W-1:0]    status_arr [NUM_GROUPS];
   logic [GROUP_W-1:0]    mask_arr   [NUM_GROUPS];
   logic [GROUP_W-1:0]    rise_arr   [NUM_GROUPS];
   logic [GROUP_W-1:0]    fall_arr   [NUM_GROUPS];
   logic [GROUP_W-1:0]    evt_arr    [NUM_GROUPS];
   logic [NUM_GROUPS-1:0] grp_active;

   logic [TOTAL_W-1:0] status_flat;
   logic [TOTAL_W-1:0] mask_flat;
   logic [TOTAL_W-1:0] evt_flat;

   for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
      logic sel;
      assign sel = wr_en && (grp_sel == GIDX_W'(g));

      if (g < EDGE_GROUPS) begin : g_pin
         irq_sync_edge #(
            .WIDTH       (GROUP_W),
            .SYNC_STAGES (SYNC_STAGES)
         ) u_edge (
            .clk     (clk),
            .rst_n   (rst_n),
            .pin     (pin_in[g*GROUP_W +: GROUP_W]),
            .we_rise (sel && (kind == KIND_RISE)),
            .we_fall (sel && (kind == KIND_FALL)),
            .wdata   (wdata),
            .rise_en (rise_arr[g]),
            .fall_en (fall_arr[g]),
            .evt     (evt_arr[g])
         );
      end else begin : g_scan
         assign rise_arr[g] = '0;
         assign fall_arr[g] = '0;
         assign evt_arr[g]  = scan_evt[(g-EDGE_GROUPS)*GROUP_W +: GROUP_W];
      end

      irq_status_group #(
         .WIDTH (GROUP_W)
      ) u_group (
         .clk     (clk),
         .rst_n   (rst_n),
         .evt     (evt_arr[g]),
         .clr_we  (sel && (kind == KIND_STATUS)),
         .mask_we (sel && (kind == KIND_MASK)),
         .wdata   (wdata),
         .status  (status_arr[g]),
         .mask    (mask_arr[g]),
         .active  (grp_active[g])
      );

      assign status_flat[g*GROUP_W +: GROUP_W] = status_arr[g];
      assign mask_flat[g*GROUP_W +: GROUP_W]   = mask_arr[g];
      assign evt_flat[g*GROUP_W +: GROUP_W]    = evt_arr[g];
   end

   always_comb begin
      rdata = '0;
      for (int g = 0; g < NUM_GROUPS; g++) begin
         if (grp_sel == GIDX_W'(g)) begin
            case (kind)
               KIND_STATUS: rdata = status_arr[g];
               KIND_MASK:   rdata = mask_arr[g];
               KIND_RISE:   rdata = rise_arr[g];
               KIND_FALL:   rdata = fall_arr[g];
               default:     rdata = '0;
            endcase
         end
      end
      if (grp_sel == GIDX_W'(NUM_GROUPS) && kind == KIND_STATUS) begin
         rdata = GROUP_W'(grp_active);
      end
   end

   assign irq_n = ~|grp_active;

endmodule

// File: rtl/irq_aggregator_chk.sv
module irq_aggregator_chk #(
   parameter int NUM_GROUPS = 3,
   parameter int GROUP_W    = 8,
   parameter int GIDX_W     = 2,
   parameter int ADDR_W     = 4
) (
   input logic                          clk,
   input logic                          rst_n,
   input logic                          wr_en,
   input logic [ADDR_W-1:0]             addr,
   input logic [GROUP_W-1:0]            wdata,
   input logic [NUM_GROUPS*GROUP_W-1:0] status_flat,
   input logic [NUM_GROUPS*GROUP_W-1:0] mask_flat,
   input logic [NUM_GROUPS*GROUP_W-1:0] evt_flat,
   input logic                          irq_n
);

   // R1: the first clock after reset release sees a clean state
   a_r1_reset_clean: assert property (@(posedge clk)
      $rose(rst_n) |-> (status_flat == '0 && mask_flat == '0 && irq_n));

   // R8: request pin follows the enabled status bits
   a_r8_pin_level: assert property (@(posedge clk) disable iff (!rst_n)
      irq_n == !(|(status_flat & mask_flat)));

   for (genvar i = 0; i < NUM_GROUPS*GROUP_W; i++) begin : g_bit
      localparam int G = i / GROUP_W;
      localparam int B = i % GROUP_W;
      logic clr_hit;
      assign clr_hit = wr_en && (addr[ADDR_W-1:2] == GIDX_W'(G))
                       && (addr[1:0] == 2'd0) && wdata[B];

      // R5: a written 1 clears the bit when no event collides
      a_r5_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
         (clr_hit && !evt_flat[i]) |=> !status_flat[i]);

      // R5: without a written 1 a set bit holds
      a_r5_zero_keeps: assert property (@(posedge clk) disable iff (!rst_n)
         (status_flat[i] && !clr_hit) |=> status_flat[i]);

      // R6 and R7: an event always leaves the bit set, masked or not
      a_r6_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
         evt_flat[i] |=> status_flat[i]);

      // R7: a bit only rises because of an event
      a_r7_no_spurious_set: assert property (@(posedge clk) disable iff (!rst_n)
         (!status_flat[i] && !evt_flat[i]) |=> !status_flat[i]);
   end

endmodule

bind irq_aggregator irq_aggregator_chk #(
   .NUM_GROUPS (NUM_GROUPS),
   .GROUP_W    (GROUP_W),
   .GIDX_W     (GIDX_W),
   .ADDR_W     (ADDR_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .wr_en       (wr_en),
   .addr        (addr),
   .wdata       (wdata),
   .status_flat (status_flat),
   .mask_flat   (mask_flat),
   .evt_flat    (evt_flat),
   .irq_n       (irq_n)
);

// File: tb/irq_aggregator_test.sv
module irq_aggregator_test;

   localparam int NG = 3;
   localparam int EG = 2;
   localparam int GW = 8;
   localparam int AW = 4;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [EG*GW-1:0]  pin_in = '0;
   logic [(NG-EG)*GW-1:0] scan_evt = '0;
   logic              wr_en = 1'b0;
   logic [AW-1:0]     addr = '0;
   logic [GW-1:0]     wdata = '0;
   logic [GW-1:0]     rdata;
   logic              irq_n;

   int n_tests = 0;
   int n_fail  = 0;

   always #5 clk = ~clk;

   irq_aggregator uut (
      .clk      (clk),
      .rst_n    (rst_n),
      .pin_in   (pin_in),
      .scan_evt (scan_evt),
      .wr_en    (wr_en),
      .addr     (addr),
      .wdata    (wdata),
      .rdata    (rdata),
      .irq_n    (irq_n)
   );

   function automatic logic [AW-1:0] ra(input int g, input int k);
      return AW'((g << 2) | k);
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [GW-1:0] d);
      wr_en = 1'b1;
      addr  = a;
      wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [AW-1:0] a, output int d);
      addr = a;
      #1;
      d = int'(rdata);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      int v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 and R10: reset values through the register map
      for (int g = 0; g < NG; g++) begin
         rd(ra(g, 0), v); chk("R1 status", v, 0);
         rd(ra(g, 1), v); chk("R1 mask", v, 0);
         rd(ra(g, 2), v); chk("R1 rise", v, (g < EG) ? 8'hFF : 0);
         rd(ra(g, 3), v); chk("R1 fall", v, 0);
      end
      chk("R1 irq_n", int'(irq_n), 1);

      // R2, R3, R7: sweep every pin bit over every polarity setting
      for (int g = 0; g < EG; g++) begin
         for (int b = 0; b < GW; b++) begin
            for (int cfg = 0; cfg < 4; cfg++) begin
               wr(ra(g, 2), cfg[0] ? GW'(1 << b) : '0);
               wr(ra(g, 3), cfg[1] ? GW'(1 << b) : '0);
               pin_in[g*GW + b] = 1'b1;
               repeat (3) @(negedge clk);
               rd(ra(g, 0), v);
               chk("R2 rise sets", v, cfg[0] ? (1 << b) : 0);
               chk("R7 masked keeps irq_n high", int'(irq_n), 1);
               wr(ra(g, 0), 8'hFF);
               pin_in[g*GW + b] = 1'b0;
               repeat (3) @(negedge clk);
               rd(ra(g, 0), v);
               chk("R3 fall sets", v, cfg[1] ? (1 << b) : 0);
               wr(ra(g, 0), 8'hFF);
            end
         end
         wr(ra(g, 2), 8'hFF);
         wr(ra(g, 3), 8'h00);
      end

      // R2 timing: not yet visible after two edges
      pin_in[0] = 1'b1;
      repeat (2) @(negedge clk);
      rd(ra(0, 0), v); chk("R2 latency early", v, 0);
      @(negedge clk);
      rd(ra(0, 0), v); chk("R2 latency exact", v, 1);
      pin_in[0] = 1'b0;
      repeat (4) @(negedge clk);
      wr(ra(0, 0), 8'hFF);

      // R4: event pulses on the event group
      for (int b = 0; b < GW; b++) begin
         scan_evt[b] = 1'b1;
         @(negedge clk);
         scan_evt[b] = 1'b0;
         rd(ra(2, 0), v); chk("R4 pulse sets", v, 1 << b);
         chk("R7 masked event irq_n", int'(irq_n), 1);
         wr(ra(2, 0), GW'(1 << b));
         rd(ra(2, 0), v); chk("R5 cleared", v, 0);
      end

      // R5: partial clears and zero writes
      scan_evt = 8'hFF;
      @(negedge clk);
      scan_evt = '0;
      wr(ra(2, 0), 8'h0F);
      rd(ra(2, 0), v); chk("R5 partial clear", v, 8'hF0);
      wr(ra(2, 0), 8'h00);
      rd(ra(2, 0), v); chk("R5 zero write keeps", v, 8'hF0);

      // R6: event and clear of the same bit in one cycle
      scan_evt = 8'h01;
      wr(ra(2, 0), 8'h11);
      scan_evt = '0;
      rd(ra(2, 0), v); chk("R6 event beats clear", v, 8'hE1);
      wr(ra(2, 0), 8'h01);
      rd(ra(2, 0), v); chk("R6 later clear", v, 8'hE0);
      scan_evt = 8'h10;
      @(negedge clk);
      scan_evt = '0;

      // R8, R9: full mask sweep over a fixed status of F0
      for (int m = 0; m < 256; m++) begin
         wr(ra(2, 1), GW'(m));
         chk("R8 irq_n vs mask", int'(irq_n), ((m & 8'hF0) != 0) ? 0 : 1);
         rd(ra(NG, 0), v);
         chk("R9 summary", v, ((m & 8'hF0) != 0) ? 4 : 0);
      end

      // R9: summary with two groups active, and writes ignored
      wr(ra(0, 1), 8'h02);
      pin_in[1] = 1'b1;
      repeat (3) @(negedge clk);
      rd(ra(NG, 0), v); chk("R9 two groups", v, 8'h05);
      wr(ra(NG, 0), 8'hFF);
      rd(ra(NG, 0), v); chk("R9 write ignored", v, 8'h05);
      wr(ra(0, 0), 8'h02);
      rd(ra(NG, 0), v); chk("R9 after clear", v, 8'h04);
      chk("R8 still low", int'(irq_n), 0);
      wr(ra(2, 0), 8'hFF);
      chk("R8 released", int'(irq_n), 1);

      // R10: unmapped addresses and event-group edge enables
      rd(ra(NG, 1), v); chk("R10 unmapped", v, 0);
      rd(ra(NG, 3), v); chk("R10 unmapped", v, 0);
      wr(ra(2, 2), 8'hFF);
      rd(ra(2, 2), v); chk("R10 event rise reads 0", v, 0);
      rd(ra(2, 3), v); chk("R10 event fall reads 0", v, 0);

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule